// File: doc/BRIEF.md
# Six-Step Bridge Gate Sequencer

This block produces the six gate commands of a three-phase half-bridge that drives a brushless DC motor with trapezoidal commutation. The electrical revolution is split into six 60-degree steps. The current step comes either from three Hall-effect sensor inputs or from a 3-bit sector number supplied by other logic. The gate pattern can change only when the step changes.

A run-time input selects one of two conduction styles. In the narrow style, two switches conduct in each step and one phase floats. In the wide style, every leg is driven in each step. A direction input reverses the order in which the steps are visited. Each leg has its own dead-time generator, which keeps the upper and lower switch of that leg from conducting together. When enabled, PWM chopping acts on the upper switches only.

Sensor codes that cannot come from a working sensor turn every gate off and raise a fault flag. The flag stays high until a valid code returns.

Top module: `sixstep_gate_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after reset, all six gate outputs and `pos_fault` are 0.
- R2: When `cond_wide`=0 the pattern for step s is as follows. The upper gate of leg floor(s/2) is on. The lower gate of leg (floor(((s+1) mod 6)/2)+1) mod 3 is on. All other gates are off. Legs A, B and C are bits 0, 1 and 2 of `gate_hi`/`gate_lo`.
- R3: When `cond_wide`=1, for step s each leg p is driven. Its upper gate is on when (s-2p) mod 6 is 0, 1 or 2; otherwise its lower gate is on.
- R4: With `use_hall`=1, the Hall codes 001, 011, 010, 110, 100 and 101 (read as `hall_in[2:0]`) map to positions 0 to 5. With `use_hall`=0, `sector_in` values 0 to 5 are the position.
- R5: Hall codes 000 and 111, and sector values 6 and 7, switch all gates off and set `pos_fault`. A valid code clears `pos_fault` and brings back the pattern for the new position.
- R6: The upper and lower gate of one leg are never on together. When a leg moves from one side to the other, both of its gates stay off for max(`dead_cycles`,1) clock cycles.
- R7: A change on `cond_wide` is applied only at a step boundary. A boundary is a change of step, or the first valid position after reset or after a fault. A mode change that arrives in the same cycle as a boundary takes effect at that boundary.
- R8: With `dir_rev`=0 the step equals the position. With `dir_rev`=1 the step is (6 - position) mod 6.
- R9: With `pwm_en`=1, each upper gate is ANDed with `pwm_cmp`. The lower gates are not affected. With `pwm_en`=0, `pwm_cmp` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| use_hall | input | 1 | 1: position from Hall inputs, 0: from sector input |
| hall_in | input | 3 | Hall sensor levels |
| sector_in | input | 3 | Sector number 0 to 5 |
| cond_wide | input | 1 | 0: two switches per step, 1: three switches per step |
| dir_rev | input | 1 | Reverse step order |
| pwm_en | input | 1 | Enable chopping of the upper switches |
| pwm_cmp | input | 1 | PWM compare result, 1 = on phase |
| dead_cycles | input | 8 | Dead time in clock cycles |
| gate_hi | output | 3 | Upper switch gates, legs C B A |
| gate_lo | output | 3 | Lower switch gates, legs C B A |
| pos_fault | output | 1 | Invalid position code seen |

## Verification
A request for a new conduction mode and a step boundary can land in the same clock cycle. The bench drives the mode input and the sector input on the same clock edge. It then checks that the settled gates show the new mode's pattern for the new step. In a separate test the mode input is changed while the step is held steady. The bench checks that the old pattern stays in place until the sector moves, and then checks the mode-change-only and the coincident cases against the pattern formulas.

// File: rtl/sixstep_pkg.sv
// Shared constants and types for the six-step gate sequencer.
// Assumes a three-leg bridge and a six-step commutation cycle.
package sixstep_pkg;

    localparam int unsigned NUM_LEGS  = 3;
    localparam int unsigned NUM_STEPS = 6;
    localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

    typedef logic [STEP_W-1:0] step_t;

    // Drive state of one bridge leg.
    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_HI  = 2'd1,
        LEG_LO  = 2'd2
    } leg_drive_e;

endpackage

// File: rtl/ss_pos_decode.sv
// Position decoder. It turns the Hall code or the sector number into a step
// index, applies the direction, and latches the conduction mode only at step
// boundaries. Assumes the inputs are already synchronised to clk.
module ss_pos_decode
    import sixstep_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  use_hall,
    input  logic  [2:0] hall_in,
    input  logic  [2:0] sector_in,
    input  logic  dir_rev,
    input  logic  mode_in,
    output step_t step_q,
    output logic  valid_q,
    output logic  fault_q,
    output logic  mode_q
);

    localparam step_t LAST_STEP = step_t'(NUM_STEPS - 1);
    localparam step_t STEP_CNT  = step_t'(NUM_STEPS);

    step_t pos;
    logic  pos_ok;
    step_t step_nxt;
    logic  boundary;

    // Map the selected source to a position and flag codes that cannot occur.
    always_comb begin
        pos    = '0;
        pos_ok = 1'b0;
        if (use_hall) begin
            case (hall_in)
                3'b001: begin pos = step_t'(0); pos_ok = 1'b1; end
                3'b011: begin pos = step_t'(1); pos_ok = 1'b1; end
                3'b010: begin pos = step_t'(2); pos_ok = 1'b1; end
                3'b110: begin pos = step_t'(3); pos_ok = 1'b1; end
                3'b100: begin pos = step_t'(4); pos_ok = 1'b1; end
                3'b101: begin pos = step_t'(5); pos_ok = 1'b1; end
                default: begin pos = '0; pos_ok = 1'b0; end
            endcase
        end else if (sector_in <= LAST_STEP) begin
            pos    = sector_in;
            pos_ok = 1'b1;
        end
    end

    // Apply the direction and detect a step boundary.
    always_comb begin
        step_nxt = (dir_rev && pos != '0) ? (STEP_CNT - pos) : pos;
        boundary = pos_ok && (!valid_q || step_nxt != step_q);
    end

    // Register the step, validity, fault flag and the boundary-aligned mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= '0;
            valid_q <= 1'b0;
            fault_q <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            valid_q <= pos_ok;
            fault_q <= !pos_ok;
            if (pos_ok) step_q <= step_nxt;
            if (boundary) mode_q <= mode_in;
        end
    end

    // R5
    bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_hall && (hall_in == 3'b000 || hall_in == 3'b111)) |=> (fault_q && !valid_q));

    // R7
    mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> (step_q != $past(step_q) || $rose(valid_q)));

endmodule

// File: rtl/ss_pattern.sv
// Pattern generator. It gives the per-leg upper and lower requests for a
// step and a conduction mode. With no valid position, every request is 0.
module ss_pattern
    import sixstep_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  step_t step,
    input  logic  valid,
    input  logic  wide,
    output logic  [NUM_LEGS-1:0] req_hi,
    output logic  [NUM_LEGS-1:0] req_lo
);

    // Look up the gate requests, bit 0 being leg A.
    always_comb begin
        req_hi = '0;
        req_lo = '0;
        if (valid) begin
            if (!wide) begin
                case (step)
                    3'd0: begin req_hi = 3'b001; req_lo = 3'b010; end
                    3'd1: begin req_hi = 3'b001; req_lo = 3'b100; end
                    3'd2: begin req_hi = 3'b010; req_lo = 3'b100; end
                    3'd3: begin req_hi = 3'b010; req_lo = 3'b001; end
                    3'd4: begin req_hi = 3'b100; req_lo = 3'b001; end
                    3'd5: begin req_hi = 3'b100; req_lo = 3'b010; end
                    default: begin req_hi = '0; req_lo = '0; end
                endcase
            end else begin
                case (step)
                    3'd0: begin req_hi = 3'b101; req_lo = 3'b010; end
                    3'd1: begin req_hi = 3'b001; req_lo = 3'b110; end
                    3'd2: begin req_hi = 3'b011; req_lo = 3'b100; end
                    3'd3: begin req_hi = 3'b010; req_lo = 3'b101; end
                    3'd4: begin req_hi = 3'b110; req_lo = 3'b001; end
                    3'd5: begin req_hi = 3'b100; req_lo = 3'b011; end
                    default: begin req_hi = '0; req_lo = '0; end
                endcase
            end
        end
    end

    // R2
    narrow_two_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !wide) |-> ($countones(req_hi) == 1 && $countones(req_lo) == 1
                              && (req_hi & req_lo) == '0));

    // R3
    wide_all_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && wide) |-> ($countones(req_hi | req_lo) == 3 && (req_hi & req_lo) == '0));

    // R5
    invalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (req_hi == '0 && req_lo == '0));

endmodule

// File: rtl/ss_leg_deadtime.sv
// Dead-time generator for one leg. A move from one side to the other passes
// through an all-off state lasting max(dead_cycles,1) cycles. A leg that has
// been off long enough turns on at once. Turn-off always happens at once.
module ss_leg_deadtime
    import sixstep_pkg::*;
#(
    parameter int unsigned DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_hi,
    input  logic              req_lo,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              drv_hi,
    output logic              drv_lo
);

    leg_drive_e        tgt;
    leg_drive_e        state_q;
    logic [DEAD_W-1:0] off_cnt_q;
    logic              gap_done;

    // Reduce the two requests to a single target state.
    always_comb begin
        if (req_hi)      tgt = LEG_HI;
        else if (req_lo) tgt = LEG_LO;
        else             tgt = LEG_OFF;
    end

    // Check whether the off interval so far covers the dead time.
    always_comb gap_done = ({1'b0, off_cnt_q} + 1'b1) >= {1'b0, dead_cycles};

    // Step the leg state and the saturating off-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= LEG_OFF;
            off_cnt_q <= '1;
        end else if (tgt == LEG_OFF) begin
            if (state_q != LEG_OFF) begin
                state_q   <= LEG_OFF;
                off_cnt_q <= '0;
            end else if (off_cnt_q != '1) begin
                off_cnt_q <= off_cnt_q + 1'b1;
            end
        end else if (tgt != state_q) begin
            if (state_q != LEG_OFF) begin
                state_q   <= LEG_OFF;
                off_cnt_q <= '0;
            end else if (gap_done) begin
                state_q <= tgt;
            end else begin
                off_cnt_q <= off_cnt_q + 1'b1;
            end
        end
    end

    assign drv_hi = (state_q == LEG_HI);
    assign drv_lo = (state_q == LEG_LO);

    // R6
    hi_to_lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LEG_HI) |=> (state_q != LEG_LO));

    // R6
    lo_to_hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LEG_LO) |=> (state_q != LEG_HI));

endmodule

// File: rtl/sixstep_gate_seq.sv
// Top level of the six-step gate sequencer. It connects the position
// decoder, the pattern generator and one dead-time generator per leg.
// The gates come out of registers, where PWM chopping is applied to the
// upper switches. Assumes pwm_cmp comes from a synchronous PWM counter.
module sixstep_gate_seq
    import sixstep_pkg::*;
#(
    parameter int unsigned DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_hall,
    input  logic [2:0]        hall_in,
    input  logic [2:0]        sector_in,
    input  logic              cond_wide,
    input  logic              dir_rev,
    input  logic              pwm_en,
    input  logic              pwm_cmp,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic [2:0]        gate_hi,
    output logic [2:0]        gate_lo,
    output logic              pos_fault
);

    step_t               step_q;
    logic                valid_q;
    logic                fault_q;
    logic                mode_q;
    logic [NUM_LEGS-1:0] req_hi;
    logic [NUM_LEGS-1:0] req_lo;
    logic [NUM_LEGS-1:0] leg_hi;
    logic [NUM_LEGS-1:0] leg_lo;
    logic [NUM_LEGS-1:0] gate_hi_q;
    logic [NUM_LEGS-1:0] gate_lo_q;
    logic                chop_off;

    ss_pos_decode u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_hall (use_hall),
        .hall_in  (hall_in),
        .sector_in(sector_in),
        .dir_rev  (dir_rev),
        .mode_in  (cond_wide),
        .step_q   (step_q),
        .valid_q  (valid_q),
        .fault_q  (fault_q),
        .mode_q   (mode_q)
    );

    ss_pattern u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step_q),
        .valid (valid_q),
        .wide  (mode_q),
        .req_hi(req_hi),
        .req_lo(req_lo)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        ss_leg_deadtime #(.DEAD_W(DEAD_W)) u_leg (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_hi     (req_hi[g]),
            .req_lo     (req_lo[g]),
            .dead_cycles(dead_cycles),
            .drv_hi     (leg_hi[g]),
            .drv_lo     (leg_lo[g])
        );
    end

    // Upper gates are masked during the off phase of the PWM.
    always_comb chop_off = pwm_en && !pwm_cmp;

    // Register the gate outputs, chopping only the upper switches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hi_q <= '0;
            gate_lo_q <= '0;
        end else begin
            gate_hi_q <= chop_off ? '0 : leg_hi;
            gate_lo_q <= leg_lo;
        end
    end

    assign gate_hi   = gate_hi_q;
    assign gate_lo   = gate_lo_q;
    assign pos_fault = fault_q;

    // R6
    leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi_q & gate_lo_q) == '0);

    // R5
    fault_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && $past(fault_q)) |=> (gate_hi_q == '0 && gate_lo_q == '0));

    // R9
    chop_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && !pwm_cmp) |=> (gate_hi_q == '0));

endmodule

// File: tb/tb_sixstep_gate_seq.sv
`timescale 1ns/1ps
module tb_sixstep_gate_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       use_hall, cond_wide, dir_rev, pwm_en, pwm_cmp;
    logic [2:0] hall_in, sector_in;
    logic [7:0] dead_cycles;
    logic [2:0] gate_hi, gate_lo;
    logic       pos_fault;

    int check_cnt = 0;
    int fail_cnt  = 0;
    bit done      = 1'b0;

    always #2.5 clk = ~clk;

    sixstep_gate_seq dut (
        .clk(clk), .rst_n(rst_n), .use_hall(use_hall), .hall_in(hall_in),
        .sector_in(sector_in), .cond_wide(cond_wide), .dir_rev(dir_rev),
        .pwm_en(pwm_en), .pwm_cmp(pwm_cmp), .dead_cycles(dead_cycles),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .pos_fault(pos_fault)
    );

    // Expected {hi,lo} from the requirement formulas.
    function automatic logic [5:0] exp_pat(input int s, input bit wide);
        logic [2:0] h = '0;
        logic [2:0] l = '0;
        if (!wide) begin
            h[s / 2] = 1'b1;
            l[((((s + 1) % 6) / 2) + 1) % 3] = 1'b1;
        end else begin
            for (int p = 0; p < 3; p++)
                if (((s - 2 * p + 12) % 6) < 3) h[p] = 1'b1; else l[p] = 1'b1;
        end
        return {h, l};
    endfunction

    function automatic logic [2:0] hall_of(input int pos);
        case (pos)
            0: return 3'b001;
            1: return 3'b011;
            2: return 3'b010;
            3: return 3'b110;
            4: return 3'b100;
            default: return 3'b101;
        endcase
    endfunction

    task automatic chk(input logic [2:0] eh, input logic [2:0] el, input logic ef, input string tag);
        check_cnt++;
        if (gate_hi !== eh || gate_lo !== el || pos_fault !== ef) begin
            fail_cnt++;
            $display("FAIL %s: hi=%b lo=%b fault=%b expected hi=%b lo=%b fault=%b",
                     tag, gate_hi, gate_lo, pos_fault, eh, el, ef);
        end
    endtask

    task automatic chk_pat(input int s, input bit wide, input string tag);
        logic [5:0] e = exp_pat(s, wide);
        chk(e[5:3], e[2:0], 1'b0, tag);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; use_hall = 1'b0; hall_in = 3'b001; sector_in = 3'd0;
        cond_wide = 1'b0; dir_rev = 1'b0; pwm_en = 1'b0; pwm_cmp = 1'b0;
        dead_cycles = 8'd2;
        settle(4);
        chk(3'b000, 3'b000, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        settle(1);
        chk(3'b000, 3'b000, 1'b0, "R1 first cycle after reset");
        settle(12);
    endtask

    task automatic t_sector_narrow();
        for (int s = 0; s < 6; s++) begin
            sector_in = 3'(s);
            settle(12);
            chk_pat(s, 1'b0, $sformatf("R2 R4 sector %0d narrow", s));
        end
    endtask

    task automatic t_sector_wide();
        cond_wide = 1'b1;
        for (int s = 0; s < 6; s++) begin
            sector_in = 3'(s);
            settle(12);
            chk_pat(s, 1'b1, $sformatf("R3 sector %0d wide", s));
        end
    endtask

    task automatic t_hall_forward();
        cond_wide = 1'b0; use_hall = 1'b1;
        for (int p = 0; p < 6; p++) begin
            hall_in = hall_of(p);
            settle(12);
            chk_pat(p, 1'b0, $sformatf("R4 hall position %0d", p));
        end
    endtask

    task automatic t_reverse();
        dir_rev = 1'b1;
        for (int p = 0; p < 6; p++) begin
            hall_in = hall_of(p);
            settle(12);
            chk_pat((6 - p) % 6, 1'b0, $sformatf("R8 reversed position %0d", p));
        end
        dir_rev = 1'b0;
    endtask

    task automatic t_fault();
        hall_in = 3'b000; settle(6);
        chk(3'b000, 3'b000, 1'b1, "R5 hall 000");
        hall_in = 3'b011; settle(12);
        chk_pat(1, 1'b0, "R5 recovery after 000");
        hall_in = 3'b111; settle(6);
        chk(3'b000, 3'b000, 1'b1, "R5 hall 111");
        use_hall = 1'b0; sector_in = 3'd7; settle(6);
        chk(3'b000, 3'b000, 1'b1, "R5 sector 7");
        sector_in = 3'd6; settle(6);
        chk(3'b000, 3'b000, 1'b1, "R5 sector 6");
        sector_in = 3'd4; settle(12);
        chk_pat(4, 1'b0, "R5 recovery on sector 4");
    endtask

    task automatic t_mode_boundary();
        sector_in = 3'd0; settle(12);
        cond_wide = 1'b1; settle(20);
        chk_pat(0, 1'b0, "R7 mode held without boundary");
        sector_in = 3'd1; settle(12);
        chk_pat(1, 1'b1, "R7 mode applied at next step");
        cond_wide = 1'b0; sector_in = 3'd2; settle(12);
        chk_pat(2, 1'b0, "R7 mode and step in same cycle");
    endtask

    task automatic t_dead(input logic [7:0] n);
        int gap = 0;
        int exp_gap;
        bit overlap = 1'b0;
        exp_gap = (n == 0) ? 1 : int'(n);
        dead_cycles = n;
        sector_in = 3'd3; settle(20);
        sector_in = 3'd0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (gate_hi[0] && gate_lo[0]) overlap = 1'b1;
            if (gate_hi[0]) break;
            if (!gate_lo[0]) gap++;
        end
        check_cnt++;
        if (gap != exp_gap || overlap) begin
            fail_cnt++;
            $display("FAIL R6 dead time N=%0d: gap=%0d overlap=%0b expected gap=%0d overlap=0",
                     n, gap, overlap, exp_gap);
        end
    endtask

    task automatic t_pwm();
        dead_cycles = 8'd2; sector_in = 3'd0; settle(12);
        pwm_en = 1'b0; pwm_cmp = 1'b0; settle(3);
        chk_pat(0, 1'b0, "R9 cmp ignored when disabled");
        pwm_en = 1'b1; settle(3);
        chk(3'b000, 3'b010, 1'b0, "R9 chop off phase");
        pwm_cmp = 1'b1; settle(2);
        chk(3'b001, 3'b010, 1'b0, "R9 chop on phase");
        pwm_cmp = 1'b0; settle(2);
        chk(3'b000, 3'b010, 1'b0, "R9 chop off again, lower kept");
        pwm_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_sector_narrow();
        t_sector_wide();
        t_hall_forward();
        t_reverse();
        t_fault();
        t_mode_boundary();
        t_dead(8'd0);
        t_dead(8'd1);
        t_dead(8'd5);
        t_pwm();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check_cnt++;
            fail_cnt++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", check_cnt - fail_cnt, check_cnt);
            $finish;
        end
    end

endmodule